// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is a slave on a two-wire serial bus that sits in front of a small internal array of bytes. It runs on a fast system clock and oversamples the bus clock (SCL) and data (SDA) lines. It pulls SDA low through an output-enable pin and never drives it high. A master selects the slave with a device byte, writes one byte at a time to a two-byte word address, and reads back from the current pointer or from an address it has just loaded. Reads can continue from one byte to the next for as long as the master keeps acknowledging.

A write takes effect only when the master ends the transfer with a stop. The block then runs a self-timed busy window and rejects every device byte until the window closes. A lock input prevents the array from being updated. Two select inputs set the address of the slave so that up to four slaves can share one bus.

State machine. **ST_IDLE** waits for a start. Any start goes to **ST_DEV**, and any stop goes to **ST_IDLE**. **ST_DEV** shifts in the device byte. On a match it goes to **ST_DEV_ACK**, otherwise to **ST_IGNORE**.

From **ST_DEV_ACK** the path depends on the direction bit:
- **Write path:** **ST_ADDR_HI** → **ST_ADDR_HI_ACK** → **ST_ADDR_LO** → **ST_ADDR_LO_ACK** → **ST_WR_DATA** → **ST_WR_DATA_ACK** → **ST_WR_HOLD**. A stop taken in **ST_WR_HOLD** commits the write.
- **Read path:** **ST_RD_DATA** → **ST_RD_ACK**. An acknowledge from the master returns to **ST_RD_DATA**. A not-acknowledge goes to **ST_IGNORE**.

Each `_ACK` state has two halves. At the first SCL fall the slave pulls SDA low. At the second SCL fall it releases SDA and moves on.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset, `sda_oe` is 0. A stop seen in any state returns the slave to idle, and the next start with a matching device byte is acknowledged.
- R2: The device byte is sent MSB first. Bits 2 and 1 must equal `chip_sel[1]` and `chip_sel[0]`, and bit 0 gives the direction (1 = read). On a mismatch the slave leaves SDA released for that byte and for every later byte until the next start.
- R3: Bits 7..3 of the device byte must be 1,0,1,0,0. Any other prefix is not acknowledged.
- R4: In a write, the slave acknowledges the high word-address byte, then the low word-address byte, then one data byte. The location used is the word address modulo 2^AW.
- R5: The array is updated only by a stop that follows the acknowledged data byte. A read of that location then returns the byte.
- R6: A committed stop starts a busy window of WR_CYCLES system clocks. A device byte that ends inside the window is not acknowledged, and one sent after the window is acknowledged.
- R7: While `wr_lock` is 1 at the stop, the array keeps its old contents. The acknowledges and the busy window are unaffected.
- R8: A pointer holds the last accessed location plus one. A committed write leaves it at the word address + 1, each byte read advances it by one, and a read started without an address returns the byte at the pointer.
- R9: A random read works as follows: device byte with direction 0, both word-address bytes, a repeated start, then a device byte with direction 1. It returns the byte at that word address.
- R10: While the master acknowledges, a read continues with successive locations, and it wraps from location 2^AW-1 to 0.
- R11: A not-acknowledge from the master ends the read. SDA stays released on every following clock until the next start.
- R12: A start received after the data byte and before any stop abandons the write. The array is unchanged, no busy window starts, and the pointer stays at the word address.
- R13: `sda_oe` changes only in the cycle after an SCL fall is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Sensed level of the SCL line |
| sda_in | input | 1 | Sensed level of the SDA line |
| chip_sel | input | 2 | Hardwired select bits compared with device-byte bits 2..1 |
| wr_lock | input | 1 | 1 = array updates suppressed |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |

## Verification
Writes are sent to three kinds of address: a plain low address, an address whose high byte must be dropped, and the four locations around the top of the array. Reads are then made as current, random and sequential transfers, so that pointer and wrap errors produce different values. Device bytes with a wrong select field, a wrong prefix, or a correct address sent during the busy window separate the three reasons for a not-acknowledge. A write with the lock set, a write abandoned by a repeated start, and a stop in the middle of an address show that the array, the busy window and the pointer change only on a committed stop. A monitor on every clock confirms that the slave never moves SDA while SCL is high.

// File: rtl/twi_eeprom_pkg.sv
package twi_eeprom_pkg;

    // Fixed upper five bits of every device byte
    localparam logic [4:0] DEV_PREFIX = 5'b10100;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR_HI,
        ST_ADDR_HI_ACK,
        ST_ADDR_LO,
        ST_ADDR_LO_ACK,
        ST_WR_DATA,
        ST_WR_DATA_ACK,
        ST_WR_HOLD,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;
    logic              scl_s;

    // Both lines idle high, so the pipeline resets to 1
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
            scl_q    <= scl_s;
            sda_q    <= sda_s;
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    // Data moving while the clock stays high marks a start or a stop
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_write_timer.sv
module twi_write_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (start) begin
            remain_q <= CW'(CYCLES);
        end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
        end
    end

    assign busy = (remain_q != '0);

    AST_BUSY_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R6

endmodule

// File: rtl/twi_byte_array.sv
module twi_byte_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= '0;
            end
        end else if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
    import twi_eeprom_pkg::*;
#(
    parameter int AW          = 8,
    parameter int WR_CYCLES   = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] chip_sel,
    input  logic       wr_lock,
    output logic       sda_oe
);
    localparam logic [3:0] LAST_BIT = 4'd7;
    localparam logic [3:0] BYTE_END = 4'd8;

    logic          sda_s, scl_rise, scl_fall, start_det, stop_det;
    twi_state_e    state_q, state_d;
    logic [3:0]    bitcnt_q;
    logic [7:0]    shreg_q, addr_hi_q, wr_data_q;
    logic [AW-1:0] ptr_q;
    logic          rw_q, ack_half_q, master_ack_q;
    logic          oe_q, oe_d;
    logic [7:0]    rx_byte, mem_rdata;
    logic          last_bit, dev_hit, commit, mem_we, busy;
    logic [2:0]    rd_idx;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_byte_array #(.AW(AW)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .addr  (ptr_q),
        .wdata (wr_data_q),
        .rdata (mem_rdata)
    );

    twi_write_timer #(.CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit),
        .busy  (busy)
    );

    assign rx_byte  = {shreg_q[6:0], sda_s};
    assign last_bit = scl_rise && (bitcnt_q == LAST_BIT);
    assign dev_hit  = (rx_byte[7:3] == DEV_PREFIX) && (rx_byte[2:1] == chip_sel) && !busy;
    assign commit   = stop_det && (state_q == ST_WR_HOLD);
    assign mem_we   = commit && !wr_lock;
    assign rd_idx   = 3'(LAST_BIT - bitcnt_q);

    // Next state and next SDA enable
    always_comb begin
        state_d = state_q;
        oe_d    = oe_q;
        if (start_det) begin
            state_d = ST_DEV;
            oe_d    = 1'b0;
        end else if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else begin
            unique case (state_q)
                ST_DEV: begin
                    if (last_bit) state_d = dev_hit ? ST_DEV_ACK : ST_IGNORE;
                end
                ST_ADDR_HI: if (last_bit) state_d = ST_ADDR_HI_ACK;
                ST_ADDR_LO: if (last_bit) state_d = ST_ADDR_LO_ACK;
                ST_WR_DATA: if (last_bit) state_d = ST_WR_DATA_ACK;
                ST_DEV_ACK, ST_ADDR_HI_ACK, ST_ADDR_LO_ACK, ST_WR_DATA_ACK: begin
                    if (scl_fall) begin
                        if (!ack_half_q) begin
                            oe_d = 1'b1;
                        end else begin
                            oe_d = 1'b0;
                            unique case (state_q)
                                ST_DEV_ACK: begin
                                    if (rw_q) begin
                                        state_d = ST_RD_DATA;
                                        oe_d    = ~mem_rdata[7];
                                    end else begin
                                        state_d = ST_ADDR_HI;
                                    end
                                end
                                ST_ADDR_HI_ACK: state_d = ST_ADDR_LO;
                                ST_ADDR_LO_ACK: state_d = ST_WR_DATA;
                                default:        state_d = ST_WR_HOLD;
                            endcase
                        end
                    end
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (bitcnt_q == BYTE_END) begin
                            oe_d    = 1'b0;
                            state_d = ST_RD_ACK;
                        end else begin
                            oe_d = ~shreg_q[rd_idx];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        if (master_ack_q) begin
                            state_d = ST_RD_DATA;
                            oe_d    = ~mem_rdata[7];
                        end else begin
                            state_d = ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shifter, bit counter, pointer and latched fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q     <= '0;
            shreg_q      <= '0;
            addr_hi_q    <= '0;
            wr_data_q    <= '0;
            ptr_q        <= '0;
            rw_q         <= 1'b0;
            ack_half_q   <= 1'b0;
            master_ack_q <= 1'b0;
        end else begin
            if (start_det || stop_det) begin
                bitcnt_q   <= '0;
                ack_half_q <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_DEV, ST_ADDR_HI, ST_ADDR_LO, ST_WR_DATA: begin
                        if (scl_rise) begin
                            shreg_q  <= rx_byte;
                            bitcnt_q <= last_bit ? 4'd0 : bitcnt_q + 4'd1;
                            if (last_bit) begin
                                ack_half_q <= 1'b0;
                                if (state_q == ST_DEV)     rw_q      <= sda_s;
                                if (state_q == ST_ADDR_HI) addr_hi_q <= rx_byte;
                                if (state_q == ST_ADDR_LO) ptr_q     <= AW'({addr_hi_q, rx_byte});
                                if (state_q == ST_WR_DATA) wr_data_q <= rx_byte;
                            end
                        end
                    end
                    ST_DEV_ACK, ST_ADDR_HI_ACK, ST_ADDR_LO_ACK, ST_WR_DATA_ACK: begin
                        if (scl_fall) begin
                            ack_half_q <= ~ack_half_q;
                            if (ack_half_q && state_q == ST_DEV_ACK && rw_q) begin
                                shreg_q  <= mem_rdata;
                                bitcnt_q <= '0;
                            end
                        end
                    end
                    ST_RD_DATA: begin
                        if (scl_rise) begin
                            bitcnt_q <= bitcnt_q + 4'd1;
                        end else if (scl_fall && bitcnt_q == BYTE_END) begin
                            ptr_q    <= ptr_q + 1'b1;
                            bitcnt_q <= '0;
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            master_ack_q <= ~sda_s;
                        end else if (scl_fall && master_ack_q) begin
                            shreg_q  <= mem_rdata;
                            bitcnt_q <= '0;
                        end
                    end
                    default: ;
                endcase
            end
            if (commit) ptr_q <= ptr_q + 1'b1;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign sda_oe = oe_q;

    AST_OE_AFTER_SCL_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(oe_q) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det))); // R13

    AST_RELEASED_OUTSIDE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_IDLE, ST_DEV, ST_ADDR_HI, ST_ADDR_LO, ST_WR_DATA,
                         ST_WR_HOLD, ST_IGNORE}) |-> !oe_q); // R2

    AST_NO_ACK_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEV_ACK) |-> !busy); // R6

    AST_READ_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RD_ACK) && ($past(state_q) == ST_RD_DATA))
        |-> (ptr_q == AW'($past(ptr_q) + 1'b1))); // R10

    AST_COMMIT_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (stop_det && !wr_lock)); // R7

endmodule

// File: tb/test_twi_eeprom_slave.sv
module test_twi_eeprom_slave;
    localparam int AW    = 8;
    localparam int WRC   = 1000;
    localparam int Q     = 8;
    localparam logic [7:0] DEV_W = 8'hA4;
    localparam logic [7:0] DEV_R = 8'hA5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [1:0] chip_sel = 2'b10;
    logic wr_lock = 1'b0;
    logic sda_oe;
    logic bus_sda;

    int n_checks = 0;
    int n_fail   = 0;
    int oe_viol  = 0;
    logic prev_oe = 1'b0;
    logic [7:0] ref_mem [256];
    int ref_ptr = 0;

    always #4 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe;

    twi_eeprom_slave #(.AW(AW), .WR_CYCLES(WRC), .SYNC_STAGES(2)) i_twi_eeprom_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (m_scl),
        .sda_in   (bus_sda),
        .chip_sel (chip_sel),
        .wr_lock  (wr_lock),
        .sda_oe   (sda_oe)
    );

    // Per-clock monitor: the slave must not move SDA while SCL is high (R13)
    always @(negedge clk) begin
        if (rst_n && (sda_oe != prev_oe) && m_scl) oe_viol++;
        prev_oe = sda_oe;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wq();
            m_scl = 1'b1; wq(); wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        acked = (bus_sda == 1'b0);
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            m_scl = 1'b1; wq();
            b[i] = bus_sda;
            wq();
            m_scl = 1'b0; wq();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] addr, input logic [7:0] data, input bit wait_done);
        bit a;
        bus_start();
        send_byte(DEV_W, a);      check(a, "R2 device ack", a, 1);
        send_byte(addr[15:8], a); check(a, "R4 addr hi ack", a, 1);
        send_byte(addr[7:0], a);  check(a, "R4 addr lo ack", a, 1);
        send_byte(data, a);       check(a, "R4 data ack", a, 1);
        bus_stop();
        if (!wr_lock) ref_mem[addr[7:0]] = data;
        ref_ptr = (int'(addr[7:0]) + 1) % 256;
        if (wait_done) repeat (WRC + 100) @(negedge clk);
    endtask

    task automatic rd_random(input logic [15:0] addr, input int n, input string tag, input bit extra);
        bit a;
        logic [7:0] b;
        bus_start();
        send_byte(DEV_W, a);      check(a, "R9 dummy write ack", a, 1);
        send_byte(addr[15:8], a); check(a, "R9 addr hi ack", a, 1);
        send_byte(addr[7:0], a);  check(a, "R9 addr lo ack", a, 1);
        bus_start();
        send_byte(DEV_R, a);      check(a, "R9 read device ack", a, 1);
        for (int k = 0; k < n; k++) begin
            logic [7:0] idx;
            idx = 8'(int'(addr[7:0]) + k);
            recv_byte(k != n - 1, b);
            check(b == ref_mem[idx], tag, b, ref_mem[idx]);
        end
        ref_ptr = (int'(addr[7:0]) + n) % 256;
        if (extra) begin
            recv_byte(1'b0, b);
            check(b == 8'hFF && sda_oe == 1'b0, "R11 released after nack", b, 8'hFF);
        end
        bus_stop();
    endtask

    task automatic rd_current(input string tag);
        bit a;
        logic [7:0] b;
        logic [7:0] idx;
        bus_start();
        send_byte(DEV_R, a); check(a, "R8 current read ack", a, 1);
        idx = 8'(ref_ptr);
        recv_byte(1'b0, b);
        check(b == ref_mem[idx], tag, b, ref_mem[idx]);
        ref_ptr = (ref_ptr + 1) % 256;
        bus_stop();
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        bit a;
        logic [7:0] b;
        for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_oe == 1'b0, "R1 reset releases SDA", sda_oe, 0);

        // Write, then probe the busy window
        do_write(16'h0010, 8'h5A, 1'b0);
        bus_start();
        send_byte(DEV_W, a); check(!a, "R6 nack while busy", a, 0);
        bus_stop();
        repeat (WRC + 100) @(negedge clk);
        bus_start();
        send_byte(DEV_W, a); check(a, "R6 ack after window", a, 1);
        bus_stop();

        rd_random(16'h0010, 1, "R5 committed byte read back", 1'b0);
        rd_current("R8 current read after random read");

        // High address byte is dropped; pointer after a write
        do_write(16'h1234, 8'hC3, 1'b1);
        rd_current("R8 current read after write");
        rd_random(16'h0034, 1, "R4 address modulo depth", 1'b0);

        // Wrap across the top of the array, then master NACK
        do_write(16'h00FE, 8'h11, 1'b1);
        do_write(16'h00FF, 8'h22, 1'b1);
        do_write(16'h0000, 8'h33, 1'b1);
        do_write(16'h0001, 8'h44, 1'b1);
        rd_random(16'h00FE, 4, "R10 sequential read with wrap", 1'b1);

        // Select mismatch, then a following byte that must be ignored
        bus_start();
        send_byte(8'hA0, a); check(!a, "R2 select mismatch nack", a, 0);
        send_byte(8'h00, a); check(!a, "R2 ignored until start", a, 0);
        bus_stop();

        // Wrong fixed prefix
        bus_start();
        send_byte(8'hB4, a); check(!a, "R3 prefix mismatch nack", a, 0);
        bus_stop();

        // Locked write leaves the array alone
        wr_lock = 1'b1;
        do_write(16'h0010, 8'h77, 1'b1);
        wr_lock = 1'b0;
        rd_random(16'h0010, 1, "R7 locked write suppressed", 1'b0);

        // Write abandoned by a repeated start
        bus_start();
        send_byte(DEV_W, a);   check(a, "R12 device ack", a, 1);
        send_byte(8'h00, a);   check(a, "R12 addr hi ack", a, 1);
        send_byte(8'h20, a);   check(a, "R12 addr lo ack", a, 1);
        send_byte(8'h99, a);   check(a, "R12 data ack", a, 1);
        bus_start();
        send_byte(DEV_R, a);   check(a, "R12 read ack", a, 1);
        recv_byte(1'b0, b);    check(b == 8'h00, "R12 array unchanged", b, 0);
        ref_ptr = 8'h21;
        bus_stop();
        bus_start();
        send_byte(DEV_W, a);   check(a, "R12 no busy window", a, 1);
        bus_stop();

        // Stop in the middle of an address returns to idle
        bus_start();
        send_byte(DEV_W, a);   check(a, "R1 device ack", a, 1);
        send_byte(8'h00, a);   check(a, "R1 addr hi ack", a, 1);
        bus_stop();
        rd_current("R1 new transfer after stop");

        check(oe_viol == 0, "R13 SDA moved with SCL high", oe_viol, 0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule